// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a small host-facing register window in front of a larger bank of internal MAC configuration registers. The host sees only three directly addressed words: a data word, a control word and a status word. To change an internal register, the host first loads the value into the data word. It then writes the control word with the register number and the write flag set. To fetch an internal register, it writes the control word with the write flag clear. Once the status word reports ready again, it reads the value from the data word.

Only one indirect access runs at a time. Ordinary targets finish after a short fixed latency. Targets at or above a configurable floor stand in for a serially managed PHY range and take much longer. The internal bank and both latency classes are modelled inside the block. The status word carries the ready bit and a sticky overrun flag. That flag records any control write the bridge had to refuse because it was busy.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset the status word reads ready=1 and overrun=0, and the data word reads 0.
- R2: The window select picks the word: 0 is the data word, 1 is the control word, 2 is the status word and 3 reads as 0. The status word has ready in bit 0 and overrun in bit 1. The control word holds the target number in bits [TGT_AW-1:0] and the write flag in bit 31. Reading select 1 returns the last accepted control word. The read data is registered, so it reflects the select one cycle later.
- R3: A control write with bit 31 set, accepted while ready, stores the current data word into the target register when the access completes.
- R4: A control write with bit 31 clear, accepted while ready, loads the target register's contents into the data word when the access completes.
- R5: Ready drops on the clock edge that accepts a control write. For a target below SLOW_BASE it stays low for exactly FAST_LAT cycles (default 4).
- R6: For a target at or above SLOW_BASE, ready stays low for exactly SLOW_LAT cycles (default 64).
- R7: A control write that arrives while ready is low starts nothing and leaves the target untouched. It sets the sticky overrun flag. This holds also in the last busy cycle.
- R8: Writing the status word with bit 1 set clears overrun. Writing it with bit 1 clear leaves overrun unchanged.
- R9: A data-word write that arrives while ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_sel | input | 2 | Window word select (0 data, 1 control, 2 status) |
| win_wr | input | 1 | Write strobe for the selected word |
| win_wdata | input | 32 | Write value |
| win_rdata | output | 32 | Registered read value of the selected word |

## Verification
Two events can land on the same clock edge. One is the completion of an access, when ready is about to rise. The other is a fresh control write from the host. The bench lines the second control write up with the final busy cycle of a fast access by counting negative edges from the accepting edge. It then judges the result three ways: the overrun flag must be set, the second target must keep its earlier value, and the first write must still have landed. A second case sends a data-word write and a control write into the middle of an access. It checks that the in-flight value survives and that only the overrun flag records the refused request.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [1:0] {
    WIN_DATA = 2'd0,
    WIN_CTRL = 2'd1,
    WIN_STAT = 2'd2,
    WIN_NONE = 2'd3
  } win_sel_e;

  localparam int unsigned WORD_W       = 32;
  localparam int unsigned CTRL_WR_BIT  = 31;
  localparam int unsigned STAT_RDY_BIT = 0;
  localparam int unsigned STAT_OVR_BIT = 1;
endpackage

// File: rtl/ibr_bank.sv
module ibr_bank #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, synchronous read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq #(
  parameter int unsigned FAST_LAT = 4,
  parameter int unsigned SLOW_LAT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic slow,
  output logic busy,
  output logic done
);
  localparam int unsigned MAX_LAT = (SLOW_LAT > FAST_LAT) ? SLOW_LAT : FAST_LAT;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_LAT - 1);
  localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(SLOW_LAT - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= slow ? SLOW_LOAD : FAST_LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // busy-span tracker for the latency checks
  logic [CNT_W:0] span;
  logic           slow_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      span   <= '0;
      slow_q <= 1'b0;
    end else if (start) begin
      span   <= (CNT_W+1)'(1);
      slow_q <= slow;
    end else if (busy) begin
      span <= span + 1'b1;
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> !busy); // R7
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> busy); // R5
  AST_FAST_SPAN: assert property (@(posedge clk) disable iff (rst) (done && !slow_q) |-> (int'(span) == int'(FAST_LAT))); // R5
  AST_SLOW_SPAN: assert property (@(posedge clk) disable iff (rst) (done && slow_q) |-> (int'(span) == int'(SLOW_LAT))); // R6
endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned TGT_AW    = 6,
  parameter int unsigned SLOW_BASE = 48,
  parameter int unsigned FAST_LAT  = 4,
  parameter int unsigned SLOW_LAT  = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  win_sel,
  input  logic        win_wr,
  input  logic [31:0] win_wdata,
  output logic [31:0] win_rdata
);
  localparam logic [TGT_AW-1:0] SLOW_FLOOR = TGT_AW'(SLOW_BASE);

  logic              busy, done;
  logic [WORD_W-1:0] data_q, ctrl_q, bank_rd;
  logic              ovr_q;
  logic              wr_data, wr_ctrl, wr_stat, start, start_slow;
  logic [TGT_AW-1:0] tgt;
  logic              tgt_write;

  assign wr_data    = win_wr && (win_sel == WIN_DATA);
  assign wr_ctrl    = win_wr && (win_sel == WIN_CTRL);
  assign wr_stat    = win_wr && (win_sel == WIN_STAT);
  assign start      = wr_ctrl && !busy;
  assign start_slow = win_wdata[TGT_AW-1:0] >= SLOW_FLOOR;
  assign tgt        = ctrl_q[TGT_AW-1:0];
  assign tgt_write  = ctrl_q[CTRL_WR_BIT];

  ibr_seq #(.FAST_LAT(FAST_LAT), .SLOW_LAT(SLOW_LAT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .slow(start_slow),
    .busy(busy), .done(done)
  );

  ibr_bank #(.DW(WORD_W), .AW(TGT_AW)) u_bank (
    .clk(clk), .we(done && tgt_write), .waddr(tgt), .wdata(data_q),
    .raddr(tgt), .rdata(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (done && !tgt_write)  data_q <= bank_rd;
      else if (wr_data && !busy) data_q <= win_wdata;
      if (start) ctrl_q <= win_wdata;
      if (wr_ctrl && busy) ovr_q <= 1'b1;
      else if (wr_stat && win_wdata[STAT_OVR_BIT]) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_rdata <= '0;
    end else begin
      unique case (win_sel)
        WIN_DATA: win_rdata <= data_q;
        WIN_CTRL: win_rdata <= ctrl_q;
        WIN_STAT: win_rdata <= {30'd0, ovr_q, !busy};
        default:  win_rdata <= '0;
      endcase
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> $stable(data_q)); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst) (wr_ctrl && busy) |=> ovr_q); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(ctrl_q)); // R7
endmodule

// File: tb/indirect_reg_bridge_bench.sv
module indirect_reg_bridge_bench;
  localparam int FAST = 4;
  localparam int SLOW = 64;
  localparam logic [31:0] WRF = 32'h8000_0000;
  localparam int NV = 6;
  localparam logic [31:0] VIDX [NV] = '{32'd0, 32'd17, 32'd47, 32'd48, 32'd55, 32'd63};
  localparam logic [31:0] VVAL [NV] = '{32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF,
                                        32'h0BAD_F00D, 32'hFFFF_0000, 32'h0000_FFFF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  win_sel = 2'd2;
  logic        win_wr = 1'b0;
  logic [31:0] win_wdata = '0;
  logic [31:0] win_rdata;
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  indirect_reg_bridge u_indirect_reg_bridge (
    .clk(clk), .rst(rst), .win_sel(win_sel), .win_wr(win_wr),
    .win_wdata(win_wdata), .win_rdata(win_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    win_sel = sel; win_wdata = val; win_wr = 1'b1;
    @(negedge clk);
    win_wr = 1'b0; win_sel = 2'd2;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!win_rdata[0] && n < 1000);
  endtask

  task automatic peek(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    win_sel = sel;
    @(negedge clk);
    val = win_rdata;
  endtask

  task automatic ind_write(input logic [31:0] idx, input logic [31:0] val, output int n);
    put(2'd0, val);
    put(2'd1, WRF | idx);
    wait_ready(n);
  endtask

  task automatic ind_read(input logic [31:0] idx, output logic [31:0] val, output int n);
    put(2'd1, idx);
    wait_ready(n);
    peek(2'd0, val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    peek(2'd2, v); chk("R1 status after reset", v, 32'd1);
    peek(2'd0, v); chk("R1 data after reset", v, 32'd0);

    // R3 R5 R6 table of writes with latency per class
    for (int i = 0; i < NV; i++) begin
      ind_write(VIDX[i], VVAL[i], n);
      chk((VIDX[i] >= 48) ? "R6 slow write span" : "R5 fast write span",
          n, (VIDX[i] >= 48) ? SLOW + 1 : FAST + 1);
    end
    // R4 readback, R5 R6 read latency
    for (int i = NV - 1; i >= 0; i--) begin
      ind_read(VIDX[i], v, n);
      chk("R4 readback", v, VVAL[i]);
      chk((VIDX[i] >= 48) ? "R6 slow read span" : "R5 fast read span",
          n, (VIDX[i] >= 48) ? SLOW + 1 : FAST + 1);
    end

    // R2 control word readback and unused select
    peek(2'd1, v); chk("R2 control word", v, 32'd0);
    put(2'd1, 32'd17); wait_ready(n);
    peek(2'd1, v); chk("R2 control word", v, 32'd17);
    peek(2'd3, v); chk("R2 select 3", v, 32'd0);

    // R7 R9 mid-access data and control writes
    ind_write(32'd6, 32'h6666_6666, n);
    put(2'd0, 32'hAAAA_0005);
    put(2'd1, WRF | 32'd5);
    put(2'd0, 32'hBBBB_BBBB);
    put(2'd1, WRF | 32'd6);
    wait_ready(n);
    peek(2'd2, v); chk("R7 overrun set", v, 32'd3);
    peek(2'd0, v); chk("R9 busy data write ignored", v, 32'hAAAA_0005);
    ind_read(32'd5, v, n); chk("R3 in-flight write landed", v, 32'hAAAA_0005);
    ind_read(32'd6, v, n); chk("R7 refused target untouched", v, 32'h6666_6666);

    // R8 clear behaviour
    put(2'd2, 32'd0);
    peek(2'd2, v); chk("R8 write 0 keeps overrun", v, 32'd3);
    put(2'd2, 32'd2);
    peek(2'd2, v); chk("R8 write 1 clears overrun", v, 32'd1);

    // R7 control write in the last busy cycle
    ind_write(32'd8, 32'h8888_0008, n);
    put(2'd0, 32'h7777_0007);
    put(2'd1, WRF | 32'd7);
    repeat (2) @(negedge clk);
    put(2'd1, WRF | 32'd8);
    wait_ready(n);
    peek(2'd2, v); chk("R7 final-cycle overrun", v, 32'd3);
    ind_read(32'd8, v, n); chk("R7 final-cycle target untouched", v, 32'h8888_0008);
    ind_read(32'd7, v, n); chk("R3 final-cycle first write", v, 32'h7777_0007);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule